// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block is a chain of storage stages that either captures a whole parallel word at once or moves its contents one place towards an output stage per clock event, taking a fresh bit from a serial input each time. Only the output stage leaves the block, as a complementary pair: the true bit and its inverse. It is used to turn a parallel word into a bit stream, or to cascade several registers into a longer chain by feeding one output into the next register's serial input.

A mode input picks the operation. While it is low, the stages follow the parallel inputs continuously, and this load takes priority over any shift. While it is high, the register shifts on each rising edge of the OR of two event inputs. Either input can act as the shift clock on its own. Holding one of them high keeps the OR high and so blocks every edge on the other, which lets that input act as a shift inhibit. The mode and both event inputs are brought onto a free-running system clock through synchronizers, so the block is fully synchronous. A shift therefore takes effect on the third system clock edge after the event input rises.

Top module: `piso_shift_reg`

## Requirements
- R1: An active-low synchronous reset clears every stage, leaving the true output 0 and the inverted output 1. The mode synchronizer resets to shift mode and the event synchronizers reset low.
- R2: The inverted output is always the complement of the true output.
- R3: While the synchronized mode input is low, every stage takes its parallel input on every system clock. Edges on the event inputs during this time cause no shift, so once mode returns high the register holds exactly the last parallel word.
- R4: With mode high and the second event input low, each rising edge on the first event input shifts the register by exactly one stage. Parallel bit 7 (the MSB) reaches the output first, and the serial input fills stage 0.
- R5: With mode high and the first event input low, each rising edge on the second event input shifts the register by one stage, exactly as in R4.
- R6: While one event input is held high, rising edges on the other input cause no shift. A falling combined signal causes no shift either.
- R7: Event inputs that are held at a steady level cause no shifts, and each rising edge of the combined signal causes only one shift.
- R8: A rising event input changes the outputs on the third system clock edge after the input rises (one more than the synchronizer depth). The outputs have not changed after the second edge.
- R9: After eight shifts, the output presents the eight serial bits in the order they were shifted in, with the earliest bit first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| par_in | input | 8 | Parallel word to load (bit 7 is shifted out first) |
| ser_in | input | 1 | Serial bit that enters stage 0 on a shift |
| load_n | input | 1 | Mode: low loads the parallel word, high allows shifting |
| evt_a | input | 1 | First shift event input |
| evt_b | input | 1 | Second shift event input, also usable as an inhibit |
| q_out | output | 1 | Output stage value |
| q_out_n | output | 1 | Complement of the output stage value |

## Verification
The assertions take for granted that par_in and ser_in are stable whenever a load or a shift is sampled, and that each level on an event input or on the mode input lasts longer than the synchronizer depth, so that no pulse is lost. The stimulus drives every input at the falling system clock edge. It holds each event level for four system clocks and keeps the data inputs fixed across each pulse. Random words, serial bits and the choice of event input come from a seeded generator. Directed sequences cover the inhibit, load override, latency and idle cases.

// File: rtl/piso_pkg.sv
package piso_pkg;

   typedef enum logic {
      MODE_LOAD  = 1'b0,
      MODE_SHIFT = 1'b1
   } piso_mode_e;

   localparam int unsigned PISO_MIN_WIDTH = 2;
   localparam int unsigned PISO_MIN_SYNC  = 2;

endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
   parameter int unsigned          WIDTH   = 1,
   parameter int unsigned          STAGES  = 2,
   parameter logic [WIDTH-1:0]     RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   logic [WIDTH-1:0] chain [STAGES];

   if (STAGES < piso_pkg::PISO_MIN_SYNC) begin : g_bad_stages
      $error("piso_sync: STAGES must be at least 2");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_chain
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain[0] <= RST_VAL;
            else        chain[0] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/piso_evt_combine.sv
module piso_evt_combine (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_a_s,
   input  logic evt_b_s,
   output logic shift_evt
);

   logic comb_now;
   logic comb_prev;

   assign comb_now = evt_a_s | evt_b_s;

   always_ff @(posedge clk) begin
      if (!rst_n) comb_prev <= 1'b0;
      else        comb_prev <= comb_now;
   end

   assign shift_evt = comb_now & ~comb_prev;

   // R7: one event per rising edge of the combined signal
   p_single_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
      shift_evt |=> !shift_evt);

   // R6: an input held high masks any edge on the other one
   p_inhibit_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_a_s && $past(evt_a_s)) |-> !shift_evt);
   p_inhibit_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_b_s && $past(evt_b_s)) |-> !shift_evt);

endmodule

// File: rtl/piso_stages.sv
module piso_stages #(
   parameter int unsigned WIDTH     = 8,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_req,
   input  logic             shift_req,
   input  logic [WIDTH-1:0] par_in,
   input  logic             ser_in,
   output logic             last_bit
);

   logic [WIDTH-1:0] stages;
   logic [WIDTH-1:0] shifted;

   if (WIDTH < piso_pkg::PISO_MIN_WIDTH) begin : g_bad_width
      $error("piso_stages: WIDTH must be at least 2");
   end

   if (MSB_FIRST) begin : g_msb_out
      assign shifted  = {stages[WIDTH-2:0], ser_in};
      assign last_bit = stages[WIDTH-1];

      // R4: contents move toward the top stage, serial bit enters stage 0
      p_shift_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (shift_req && !load_req) |=>
            (stages == {$past(stages[WIDTH-2:0]), $past(ser_in)}));
   end else begin : g_lsb_out
      assign shifted  = {ser_in, stages[WIDTH-1:1]};
      assign last_bit = stages[0];

      p_shift_lsb_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (shift_req && !load_req) |=>
            (stages == {$past(ser_in), $past(stages[WIDTH-1:1])}));
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         stages <= '0;
      else if (load_req)  stages <= par_in;
      else if (shift_req) stages <= shifted;
   end

   // R1: reset empties the register
   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (stages == '0));

   // R3: load follows the parallel word and wins over a shift
   p_load_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      load_req |=> (stages == $past(par_in)));

   // R7: without a request the contents hold
   p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_req && !shift_req) |=> $stable(stages));

endmodule

// File: rtl/piso_shift_reg.sv
module piso_shift_reg #(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          MSB_FIRST   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] par_in,
   input  logic             ser_in,
   input  logic             load_n,
   input  logic             evt_a,
   input  logic             evt_b,
   output logic             q_out,
   output logic             q_out_n
);

   import piso_pkg::*;

   localparam int unsigned CTRL_W = 3;
   localparam logic [CTRL_W-1:0] CTRL_RST = {1'b1, 1'b0, 1'b0};

   logic [CTRL_W-1:0] ctrl_raw;
   logic [CTRL_W-1:0] ctrl_s;
   piso_mode_e        mode_s;
   logic              shift_evt;
   logic              load_req;
   logic              shift_req;
   logic              last_bit;

   assign ctrl_raw = {load_n, evt_a, evt_b};

   piso_sync #(
      .WIDTH   (CTRL_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (CTRL_RST)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (ctrl_raw),
      .q_sync  (ctrl_s)
   );

   assign mode_s = piso_mode_e'(ctrl_s[2]);

   piso_evt_combine u_evt (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_a_s   (ctrl_s[1]),
      .evt_b_s   (ctrl_s[0]),
      .shift_evt (shift_evt)
   );

   assign load_req  = (mode_s == MODE_LOAD);
   assign shift_req = (mode_s == MODE_SHIFT) && shift_evt;

   piso_stages #(
      .WIDTH     (WIDTH),
      .MSB_FIRST (MSB_FIRST)
   ) u_stages (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_req  (load_req),
      .shift_req (shift_req),
      .par_in    (par_in),
      .ser_in    (ser_in),
      .last_bit  (last_bit)
   );

   assign q_out   = last_bit;
   assign q_out_n = ~last_bit;

endmodule

// File: tb/piso_shift_reg_test.sv
module piso_shift_reg_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] par_in = '0;
   logic       ser_in = 1'b0;
   logic       load_n = 1'b1;
   logic       evt_a = 1'b0;
   logic       evt_b = 1'b0;
   logic       q_out;
   logic       q_out_n;

   int unsigned n_cmp = 0;
   int unsigned n_bad = 0;
   int unsigned cycles = 0;
   logic [7:0]  model = '0;

   always #10 clk = ~clk;

   piso_shift_reg uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .par_in  (par_in),
      .ser_in  (ser_in),
      .load_n  (load_n),
      .evt_a   (evt_a),
      .evt_b   (evt_b),
      .q_out   (q_out),
      .q_out_n (q_out_n)
   );

   function automatic logic [7:0] shift_model(input logic [7:0] cur, input logic s);
      return {cur[6:0], s};
   endfunction

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic check_out(input string req);
      n_cmp++;
      if (q_out !== model[7] || q_out_n !== ~model[7]) begin
         n_bad++;
         $display("FAIL %s: q=%b qn=%b expected q=%b qn=%b", req, q_out, q_out_n,
                  model[7], ~model[7]);
      end
   endtask

   task automatic do_load(input logic [7:0] v);
      par_in = v;
      load_n = 1'b0;
      tick(4);
      load_n = 1'b1;
      tick(4);
      model = v;
   endtask

   task automatic do_shift(input logic use_b, input logic s);
      ser_in = s;
      if (use_b) evt_b = 1'b1; else evt_a = 1'b1;
      tick(4);
      if (use_b) evt_b = 1'b0; else evt_a = 1'b0;
      tick(4);
      model = shift_model(model, s);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog: cycles=%0d expected <= 150000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
         end
      end
   end

   initial begin
      logic [7:0] ser_hist;
      void'($urandom(32'd1234));
      tick(5);
      rst_n = 1'b1;
      tick(1);
      model = '0;
      check_out("R1 reset state");
      check_out("R2 reset complement");

      // R3: load, with event edges ignored while loading
      par_in = 8'h5A;
      load_n = 1'b0;
      tick(3);
      evt_a = 1'b1; tick(3); evt_a = 1'b0; tick(3);
      load_n = 1'b1;
      tick(4);
      model = 8'h5A;
      check_out("R3 load override");
      do_shift(1'b0, 1'b0);
      check_out("R3 first shift after load");

      // R8: latency of a shift
      do_load(8'h80);
      check_out("R8 before edge");
      ser_in = 1'b0;
      evt_a = 1'b1;
      tick(2);
      check_out("R8 unchanged after two edges");
      tick(1);
      model = shift_model(model, 1'b0);
      check_out("R8 changed on third edge");
      tick(1);
      evt_a = 1'b0;
      tick(4);

      // R4/R5/R9: random words, random event input, random serial bits
      for (int it = 0; it < 16; it++) begin
         do_load(8'($urandom));
         check_out("R3 random load");
         ser_hist = '0;
         for (int k = 0; k < 8; k++) begin
            logic sb;
            logic ub;
            sb = 1'($urandom);
            ub = 1'($urandom);
            ser_hist = {ser_hist[6:0], sb};
            do_shift(ub, sb);
            if (ub) check_out("R5 shift via evt_b");
            else    check_out("R4 shift via evt_a");
         end
         n_cmp++;
         if (model !== ser_hist) begin
            n_bad++;
            $display("FAIL R9: model=%h expected %h", model, ser_hist);
         end
         for (int k = 0; k < 8; k++) begin
            n_cmp++;
            if (q_out !== ser_hist[7-k]) begin
               n_bad++;
               $display("FAIL R9 serial order bit %0d: q=%b expected %b", k, q_out,
                        ser_hist[7-k]);
            end
            do_shift(1'b0, 1'b0);
         end
      end

      // R6: evt_b held high inhibits evt_a
      ser_in = 1'b0;
      evt_b = 1'b1;
      tick(4);
      model = shift_model(model, 1'b0);
      do_load(8'hB4);
      for (int k = 0; k < 3; k++) begin
         evt_a = 1'b1; tick(4); evt_a = 1'b0; tick(4);
      end
      check_out("R6 evt_b inhibits evt_a");
      evt_b = 1'b0;
      tick(4);
      check_out("R6 falling combined no shift");

      // R6: evt_a held high inhibits evt_b
      evt_a = 1'b1;
      tick(4);
      model = shift_model(model, 1'b0);
      check_out("R6 raising evt_a shifts once");
      for (int k = 0; k < 3; k++) begin
         evt_b = 1'b1; tick(4); evt_b = 1'b0; tick(4);
      end
      check_out("R6 evt_a inhibits evt_b");
      evt_a = 1'b0;
      tick(4);

      // R7: static inputs, no shifts
      do_load(8'h6C);
      tick(30);
      check_out("R7 idle hold");
      do_shift(1'b1, 1'b1);
      check_out("R7 one shift per edge");
      check_out("R2 complement");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule